// File: doc/BRIEF.md
# CPU Clock Stretcher and RAM Slot Arbiter

This block sits between a 2 MHz base timing source and an 8-bit CPU whose RAM is shared with a display fetcher. Every base period of 500 ns is one RAM byte slot. The slots are owned in strict alternation, one by the CPU and the next by the display, so each side is guaranteed one byte every microsecond. A display-owned slot is never handed to the CPU, even when the display has nothing to fetch.

The CPU clock enable `cpu_ce` marks the base period in which the current CPU cycle completes. A cycle that does not touch RAM completes in a single period. A RAM cycle that begins in a display slot is held for one extra period and completes in the next CPU slot. The CPU sees one longer cycle, and sustained RAM traffic runs at 1 MHz.

A 6-bit line position counts the 1 µs steps of a 64-step display line. In high-bandwidth display modes the CPU is halted for the whole active part of the line. By default the active part is the first 40 steps, taken from the internal counter. When a parameter is set, the active part comes from an external flag instead.

Top module: `ram_slot_arbiter`

## Requirements
- R1: While reset is held and in the first period after reset, `grant_cpu`=1, `grant_disp`=0 and `line_pos`=0.
- R2: Exactly one of `grant_cpu` and `grant_disp` is high in every period, and ownership flips on every base clock edge.
- R3: Grants depend on nothing but time since reset. `cpu_ram`, `hibw_mode` and `line_active_in` never change them.
- R4: When `cpu_ram`=0 and the CPU is not halted, `cpu_ce`=1 in every period, whichever side owns the slot.
- R5: When `cpu_ram`=1 and the CPU is not halted, `cpu_ce` equals `grant_cpu`. In a display-owned slot the block drives `cpu_hold`=1 and `cpu_ce`=0, so that cycle completes in the next CPU slot.
- R6: `line_pos` advances by one at the end of each display-owned slot, stays unchanged across the end of a CPU-owned slot, and wraps from 63 to 0.
- R7: With `hibw_mode`=1 and the line active, `cpu_halt`=1, `cpu_ce`=0 and `cpu_hold`=0.
- R8: With `hibw_mode`=0, or when the line is not active, `cpu_halt`=0. With the internal window, the line is active exactly when `line_pos` < 40.
- R9: With the default EXT_ACTIVE=0, `line_active_in` has no effect on any output.
- R10: With EXT_ACTIVE=1, the line is active exactly when `line_active_in`=1, and the internal count plays no part in halting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz base clock; one period is one RAM byte slot |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ram | input | 1 | The current CPU cycle targets RAM |
| hibw_mode | input | 1 | A high-bandwidth display mode is selected |
| line_active_in | input | 1 | External display-line-active flag, used when EXT_ACTIVE=1 |
| cpu_ce | output | 1 | The CPU cycle completes at the end of this period |
| cpu_hold | output | 1 | The CPU clock phase is held to stretch a RAM cycle |
| cpu_halt | output | 1 | The CPU is stopped for the display line |
| grant_cpu | output | 1 | The CPU owns this RAM slot |
| grant_disp | output | 1 | The display owns this RAM slot |
| line_pos | output | 6 | Position in the display line, in 1 µs steps |

## Verification
The assertions assume that `cpu_ram` and `hibw_mode` are settled before the clock edge that ends a period and stay constant within the period. The stimulus therefore changes every input only on the falling edge and samples the outputs just after it. The assertions also assume that reset is released on a period boundary, so that the first slot after reset belongs to the CPU. The stimulus mixes runs of RAM-only, ROM-only and interleaved cycles with both display modes, and it toggles `line_active_in` freely. The runs are long enough to cross the edges of the active window and the wrap of the line counter more than once.

// File: rtl/ram_slot_pkg.sv
package ram_slot_pkg;

  typedef enum logic {OWNER_CPU = 1'b0, OWNER_DISP = 1'b1} slot_owner_t;

  // Line position that follows pos in a line of len steps.
  function automatic int step_pos(int pos, int len);
    return (pos >= len - 1) ? 0 : pos + 1;
  endfunction

  // Active part of the line when it is timed from the internal count.
  function automatic logic pos_in_window(int pos, int active_len);
    return pos < active_len;
  endfunction

endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import ram_slot_pkg::*;
#(
  parameter int LINE_CYCLES = 64,
  localparam int CW = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output slot_owner_t   owner,
  output logic          line_step,
  output logic [CW-1:0] pos
);

  slot_owner_t owner_q;
  logic [CW-1:0] pos_q;

  // The line advances once per pair of slots, as the display slot ends.
  assign line_step = (owner_q == OWNER_DISP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWNER_CPU;
      pos_q   <= '0;
    end else begin
      owner_q <= (owner_q == OWNER_CPU) ? OWNER_DISP : OWNER_CPU;
      if (line_step)
        pos_q <= CW'(step_pos(int'(pos_q), LINE_CYCLES));
    end
  end

  assign owner = owner_q;
  assign pos   = pos_q;

endmodule

// File: rtl/window_select.sv
module window_select
  import ram_slot_pkg::*;
#(
  parameter int LINE_CYCLES   = 64,
  parameter int ACTIVE_CYCLES = 40,
  parameter bit EXT_ACTIVE    = 1'b0,
  localparam int CW = $clog2(LINE_CYCLES)
) (
  input  logic [CW-1:0] pos,
  input  logic          ext_active,
  input  logic          hibw_mode,
  output logic          line_active,
  output logic          halt
);

  logic internal_active;
  assign internal_active = pos_in_window(int'(pos), ACTIVE_CYCLES);

  // The parameter picks the source; both candidates stay in the expression.
  assign line_active = EXT_ACTIVE ? ext_active : internal_active;
  assign halt        = hibw_mode & line_active;

endmodule

// File: rtl/cpu_clock_gate.sv
module cpu_clock_gate
  import ram_slot_pkg::*;
(
  input  slot_owner_t owner,
  input  logic        cpu_ram,
  input  logic        halt,
  output logic        ce,
  output logic        hold
);

  logic slot_ok;

  // A RAM cycle may only finish in a CPU slot; other cycles finish in any slot.
  always_comb begin
    slot_ok = !cpu_ram || (owner == OWNER_CPU);
    ce      = !halt && slot_ok;
    hold    = !halt && !slot_ok;
  end

endmodule

// File: rtl/ram_slot_arbiter.sv
module ram_slot_arbiter
  import ram_slot_pkg::*;
#(
  parameter int LINE_CYCLES   = 64,
  parameter int ACTIVE_CYCLES = 40,
  parameter bit EXT_ACTIVE    = 1'b0,
  localparam int CW = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_ram,
  input  logic          hibw_mode,
  input  logic          line_active_in,
  output logic          cpu_ce,
  output logic          cpu_hold,
  output logic          cpu_halt,
  output logic          grant_cpu,
  output logic          grant_disp,
  output logic [CW-1:0] line_pos
);

  slot_owner_t owner;
  logic        line_step;
  logic        line_active;

  slot_sequencer #(.LINE_CYCLES(LINE_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner     (owner),
    .line_step (line_step),
    .pos       (line_pos)
  );

  window_select #(
    .LINE_CYCLES   (LINE_CYCLES),
    .ACTIVE_CYCLES (ACTIVE_CYCLES),
    .EXT_ACTIVE    (EXT_ACTIVE)
  ) u_win (
    .pos         (line_pos),
    .ext_active  (line_active_in),
    .hibw_mode   (hibw_mode),
    .line_active (line_active),
    .halt        (cpu_halt)
  );

  cpu_clock_gate u_gate (
    .owner   (owner),
    .cpu_ram (cpu_ram),
    .halt    (cpu_halt),
    .ce      (cpu_ce),
    .hold    (cpu_hold)
  );

  assign grant_cpu  = (owner == OWNER_CPU);
  assign grant_disp = (owner == OWNER_DISP);

endmodule

// File: rtl/ram_slot_arbiter_chk.sv
module ram_slot_arbiter_chk #(
  parameter int LINE_CYCLES = 64,
  localparam int CW = $clog2(LINE_CYCLES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ram,
  input logic          cpu_ce,
  input logic          cpu_hold,
  input logic          cpu_halt,
  input logic          grant_cpu,
  input logic          grant_disp,
  input logic          line_step,
  input logic [CW-1:0] line_pos
);

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({grant_cpu, grant_disp}) == 1); // R2

  AST_CPU_THEN_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    grant_cpu |=> grant_disp); // R2

  AST_DISP_THEN_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    grant_disp |=> grant_cpu); // R2

  AST_ROM_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ram && !cpu_halt) |-> cpu_ce); // R4

  AST_RAM_IN_CPU_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && cpu_ram) |-> grant_cpu); // R5

  AST_HOLD_IN_DISP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold |-> (grant_disp && cpu_ram && !cpu_ce)); // R5

  AST_POS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    grant_cpu |=> $stable(line_pos)); // R6

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_step && line_pos == CW'(LINE_CYCLES - 1)) |=> line_pos == '0); // R6

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (!cpu_ce && !cpu_hold)); // R7

endmodule

bind ram_slot_arbiter ram_slot_arbiter_chk #(.LINE_CYCLES(LINE_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_ram    (cpu_ram),
  .cpu_ce     (cpu_ce),
  .cpu_hold   (cpu_hold),
  .cpu_halt   (cpu_halt),
  .grant_cpu  (grant_cpu),
  .grant_disp (grant_disp),
  .line_step  (line_step),
  .line_pos   (line_pos)
);

// File: tb/ram_slot_arbiter_test.sv
module ram_slot_arbiter_test;

  localparam int CLK_PERIOD = 500;
  localparam int LINE  = 64;
  localparam int ACT   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_ram = 1'b0, hibw_mode = 1'b0, line_active_in = 1'b0;
  logic ce, hold, halt, gc, gd;
  logic [5:0] pos;
  logic ce_x, hold_x, halt_x, gc_x, gd_x;
  logic [5:0] pos_x;

  int vectors = 0;
  int miscompares = 0;
  int k = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ram_slot_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cpu_ram(cpu_ram), .hibw_mode(hibw_mode),
    .line_active_in(line_active_in), .cpu_ce(ce), .cpu_hold(hold),
    .cpu_halt(halt), .grant_cpu(gc), .grant_disp(gd), .line_pos(pos));

  ram_slot_arbiter #(.EXT_ACTIVE(1'b1)) uut_ext (
    .clk(clk), .rst_n(rst_n), .cpu_ram(cpu_ram), .hibw_mode(hibw_mode),
    .line_active_in(line_active_in), .cpu_ce(ce_x), .cpu_hold(hold_x),
    .cpu_halt(halt_x), .grant_cpu(gc_x), .grant_disp(gd_x), .line_pos(pos_x));

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at slot %0d: actual %0d expected %0d", tag, k, act, exp);
    end
  endtask

  // Reference: ownership and line position follow time since reset only.
  task automatic compare_all();
    bit cpu_slot = (k % 2) == 0;
    int mpos = (k / 2) % LINE;
    bit m_halt = hibw_mode && (mpos < ACT);
    bit m_halt_x = hibw_mode && line_active_in;
    bit m_ce = !m_halt && (!cpu_ram || cpu_slot);
    bit m_ce_x = !m_halt_x && (!cpu_ram || cpu_slot);
    check("R2 grant_cpu", gc, cpu_slot);
    check("R2 grant_disp", gd, !cpu_slot);
    check("R3 ext grant_cpu", gc_x, cpu_slot);
    check("R6 line_pos", pos, mpos);
    check("R8 cpu_halt", halt, m_halt);
    check(cpu_ram ? "R5 cpu_ce" : "R4 cpu_ce", ce, m_ce);
    check("R5 cpu_hold", hold, !m_halt && cpu_ram && !cpu_slot);
    if (m_halt) check("R7 halted ce", ce, 0);
    check("R9 halt ignores line_active_in", halt, m_halt);
    check("R10 ext halt", halt_x, m_halt_x);
    check("R10 ext cpu_ce", ce_x, m_ce_x);
  endtask

  task automatic run(int n, int pattern, bit hib);
    for (int i = 0; i < n; i++) begin
      hibw_mode = hib;
      case (pattern)
        0: cpu_ram = 1'b1;
        1: cpu_ram = 1'b0;
        2: cpu_ram = ((i * 7 + i / 3) % 3) == 0;
        default: cpu_ram = (i % 5) < 2;
      endcase
      line_active_in = ((i / 9) % 2) == 1;
      #1;
      compare_all();
      @(posedge clk);
      k++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset grant_cpu", gc, 1);
    check("R1 reset grant_disp", gd, 0);
    check("R1 reset line_pos", pos, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(40, 0, 1'b0);
    run(40, 1, 1'b0);
    run(150, 2, 1'b0);
    run(300, 3, 1'b1);
    run(200, 2, 1'b1);
    run(100, 0, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule